// File: doc/BRIEF.md
# Infrared Carrier Edge Timestamp Unit

This block measures an incoming infrared carrier by stamping the value of a free-running counter whenever the carrier crosses in the expected direction. Software arms a capture run, and the unit records the counter on alternating falling and rising edges. From the three most recent stamps, software can derive the carrier period and its high and low times. The start direction is selectable. A run ends in one of two ways: after a fixed number of edges (single mode), or when the counter reaches a programmable terminal value (continuous mode).

Independently of capture, an edge interrupt flag is raised on the falling edge, the rising edge or both edges of the polarity-adjusted carrier. The flag is cleared by a software write of 0 or by an acknowledge pulse. When capture is disabled, the counter simply runs as a plain wrapping timer.

The register interface is a 7-bit control write/read port, a 16-bit terminal-value write port and an acknowledge strobe. Control bits: bit0 enable, bit1 polarity, bit2 single mode, bit3 start phase, bit4 interrupt on falling edge, bit5 interrupt on rising edge, bit6 interrupt flag.

Top module: `ir_edge_capture`

## Requirements
- R1: After reset, the control bits, the terminal value, the counter, all capture slots, the done flag and the interrupt flag are 0.
- R2: The carrier passes through a two-flop synchronizer. If `ir_in` changes after clock edge k, a qualifying edge stores the `count` value that is visible between edges k+2 and k+3, and that value appears in capture slot 0 after edge k+3.
- R3: With enable (bit0) at 0, `count` increments by one on every clock and wraps, and the capture slots never change.
- R4: With polarity (bit1) at 1, the carrier is used as received. With polarity at 0, it is inverted. Changing polarity while the carrier is steady produces no edge: no capture and no interrupt.
- R5: The start phase (bit3), sampled when the run is armed, picks the first captured direction: 0 means falling first, 1 means rising first. Captures then alternate direction.
- R6: In single mode (bit2 = 1), the third capture sets `done`. While `done` is 1 and enable is 1, `count` holds and no further captures occur.
- R7: In continuous mode (bit2 = 0), captures alternate until `count` equals the terminal value. In that cycle `done` is set, and `count` then holds at the terminal value.
- R8: A control write with bit0 = 1 re-arms the run: `count` goes to 0, `done` to 0, and the sequence restarts at the start phase. The capture slots keep their contents.
- R9: An edge in the direction other than the one expected next stores nothing and does not advance the sequence.
- R10: The interrupt flag (bit6) is set one clock after a falling edge when bit4 is 1, or after a rising edge when bit5 is 1, whether or not capture is enabled.
- R11: The interrupt flag is cleared by a control write with bit6 = 0 or by `irq_ack`. An edge that sets the flag in the same cycle takes priority over the clear.
- R12: Captures shift through three slots. Slot 0 (`cap_data[15:0]`) holds the newest capture and slot 2 (`cap_data[47:32]`) the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Asynchronous infrared carrier |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 7 | Control write data |
| term_we | input | 1 | Terminal value write strobe |
| term_wdata | input | 16 | Terminal value |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| ctrl_rdata | output | 7 | Control readback, including the interrupt flag |
| count | output | 16 | Capture counter |
| cap_data | output | 48 | Three capture slots, slot 0 in the low bits |
| done | output | 1 | Capture run finished |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions assume that the register strobes are synchronous single-cycle pulses and that `ir_in` holds each level for at least one clock, so that no pulse is lost in the synchronizer. The stimulus drives every input half a cycle away from the active edge. Carrier toggles are at least one cycle apart, and register writes are random but always complete, so the stimulus stays inside these assumptions. The stamped values depend on the exact synchronizer latency, so the bench model repeats the three-register delay behaviourally.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
   localparam int CTL_W      = 7;
   localparam int CTL_EN     = 0;
   localparam int CTL_POL    = 1;
   localparam int CTL_SINGLE = 2;
   localparam int CTL_PHASE  = 3;
   localparam int CTL_IRQ_F  = 4;
   localparam int CTL_IRQ_R  = 5;
   localparam int CTL_IRQ    = 6;

   typedef struct packed {
      logic irq_r;
      logic irq_f;
      logic phase;
      logic single;
      logic pol;
      logic en;
   } ctl_t;

   function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] d);
      ctl_t c;
      c.en     = d[CTL_EN];
      c.pol    = d[CTL_POL];
      c.single = d[CTL_SINGLE];
      c.phase  = d[CTL_PHASE];
      c.irq_f  = d[CTL_IRQ_F];
      c.irq_r  = d[CTL_IRQ_R];
      return c;
   endfunction
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ir_cap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ir_cap_edge.sv
module ir_cap_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   input  logic pol,
   output logic rise,
   output logic fall
);
   logic prev_raw;
   logic cur, prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_raw <= 1'b0;
      else        prev_raw <= s;
   end

   // polarity applied to both samples: a polarity change alone is no edge
   assign cur  = pol ? s        : ~s;
   assign prv  = pol ? prev_raw : ~prev_raw;
   assign rise = cur & ~prv;
   assign fall = ~cur & prv;

   a_r4_steady_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (s == prev_raw) |-> !(rise || fall));
endmodule

// File: rtl/ir_cap_irq.sv
module ir_cap_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   input  logic fall,
   input  logic sel_r,
   input  logic sel_f,
   input  logic sw_clr,
   input  logic ack,
   output logic irq
);
   logic set;
   assign set = (rise & sel_r) | (fall & sel_f);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              irq <= 1'b0;
      else if (set)            irq <= 1'b1;
      else if (sw_clr || ack)  irq <= 1'b0;
   end

   a_r10_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && sel_r) |=> irq);
   a_r10_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && sel_f) |=> irq);
   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(rise && sel_r) && !(fall && sel_f)) |=> !irq);
endmodule

// File: rtl/ir_cap_seq.sv
module ir_cap_seq #(
   parameter int CNT_W        = 16,
   parameter int N_CAP        = 3,
   parameter int SINGLE_EDGES = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   single,
   input  logic                   rearm,
   input  logic                   rearm_phase,
   input  logic [CNT_W-1:0]       term,
   input  logic                   rise,
   input  logic                   fall,
   output logic [CNT_W-1:0]       count,
   output logic [N_CAP*CNT_W-1:0] cap_bus,
   output logic                   done
);
   localparam int IDX_W = $clog2(SINGLE_EDGES + 1);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SINGLE_EDGES - 1);
   localparam logic [IDX_W-1:0] SAT  = IDX_W'(SINGLE_EDGES);

   if (N_CAP < 1) begin : g_bad_ncap
      $error("ir_cap_seq: N_CAP must be at least 1");
   end
   if (SINGLE_EDGES < 1) begin : g_bad_edges
      $error("ir_cap_seq: SINGLE_EDGES must be at least 1");
   end

   logic [IDX_W-1:0] idx;
   logic             exp_rise;
   logic             hit;
   logic             fire;

   assign hit  = exp_rise ? rise : fall;
   assign fire = !rearm && en && !done && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         idx      <= '0;
         exp_rise <= 1'b0;
         done     <= 1'b0;
      end else if (rearm) begin
         count    <= '0;
         idx      <= '0;
         exp_rise <= rearm_phase;
         done     <= 1'b0;
      end else if (!en) begin
         count <= count + CNT_W'(1);
      end else if (!done) begin
         if (hit) begin
            exp_rise <= ~exp_rise;
            if (idx != SAT) idx <= idx + IDX_W'(1);
         end
         if (single) begin
            count <= count + CNT_W'(1);
            if (hit && idx == LAST) done <= 1'b1;
         end else if (count == term) begin
            done <= 1'b1;
         end else begin
            count <= count + CNT_W'(1);
         end
      end
   end

   logic [CNT_W-1:0] slot [N_CAP];

   for (genvar i = 0; i < N_CAP; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    slot[i] <= '0;
         else if (fire) slot[i] <= (i == 0) ? count : slot[(i == 0) ? 0 : i-1];
      end
      assign cap_bus[i*CNT_W +: CNT_W] = slot[i];
   end

   a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> (count == '0 && !done));
   a_r6_hold_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      (en && done && !rearm) |=> ($stable(count) && $stable(cap_bus)));
   a_r3_free_timer: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !rearm) |=> (count == $past(count) + CNT_W'(1)));
   a_r3_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cap_bus));
   a_r7_terminal: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !done && !single && !rearm && count == term) |=> (done && $stable(count)));
endmodule

// File: rtl/ir_edge_capture.sv
module ir_edge_capture #(
   parameter int CNT_W        = 16,
   parameter int N_CAP        = 3,
   parameter int SINGLE_EDGES = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ir_in,
   input  logic                   ctrl_we,
   input  logic [6:0]             ctrl_wdata,
   input  logic                   term_we,
   input  logic [CNT_W-1:0]       term_wdata,
   input  logic                   irq_ack,
   output logic [6:0]             ctrl_rdata,
   output logic [CNT_W-1:0]       count,
   output logic [N_CAP*CNT_W-1:0] cap_data,
   output logic                   done,
   output logic                   irq
);
   import ir_cap_pkg::*;

   ctl_t             ctl;
   logic [CNT_W-1:0] term;
   logic             s_ir, rise, fall;
   logic             rearm, sw_clr;

   assign rearm  = ctrl_we &  ctrl_wdata[CTL_EN];
   assign sw_clr = ctrl_we & ~ctrl_wdata[CTL_IRQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         term <= '0;
      end else begin
         if (ctrl_we) ctl  <= ctl_unpack(ctrl_wdata);
         if (term_we) term <= term_wdata;
      end
   end

   ir_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ir_in), .q(s_ir));

   ir_cap_edge u_edge (
      .clk(clk), .rst_n(rst_n), .s(s_ir), .pol(ctl.pol),
      .rise(rise), .fall(fall));

   ir_cap_irq u_irq (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
      .sel_r(ctl.irq_r), .sel_f(ctl.irq_f),
      .sw_clr(sw_clr), .ack(irq_ack), .irq(irq));

   ir_cap_seq #(.CNT_W(CNT_W), .N_CAP(N_CAP), .SINGLE_EDGES(SINGLE_EDGES)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(ctl.en), .single(ctl.single),
      .rearm(rearm), .rearm_phase(ctrl_wdata[CTL_PHASE]), .term(term),
      .rise(rise), .fall(fall), .count(count), .cap_bus(cap_data), .done(done));

   assign ctrl_rdata = {irq, ctl.irq_r, ctl.irq_f, ctl.phase, ctl.single, ctl.pol, ctl.en};
endmodule

// File: tb/sim_ir_edge_capture.sv
`timescale 1ns/1ps
module sim_ir_edge_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ir_in = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [6:0]  ctrl_wdata = '0;
   logic        term_we = 1'b0;
   logic [15:0] term_wdata = '0;
   logic        irq_ack = 1'b0;
   logic [6:0]  ctrl_rdata;
   logic [15:0] count;
   logic [47:0] cap_data;
   logic        done, irq;

   int n_chk = 0, n_bad = 0, cyc = 0;

   always #2.5 clk = ~clk;

   ir_edge_capture u0 (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit        m_s1, m_s2, m_prev, m_irq, m_exp, m_done;
   bit [5:0]  m_ctl;
   bit [15:0] m_term, m_cnt;
   bit [15:0] m_cap [3];
   int        m_idx;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0; m_exp = 0; m_done = 0;
         m_ctl = 0; m_term = 0; m_cnt = 0; m_idx = 0;
         foreach (m_cap[i]) m_cap[i] = 0;
      end else begin
         bit a, b, rs, fl, hit;
         a  = m_ctl[1] ? m_s2   : !m_s2;
         b  = m_ctl[1] ? m_prev : !m_prev;
         rs = a && !b;
         fl = !a && b;
         if ((rs && m_ctl[5]) || (fl && m_ctl[4])) m_irq = 1;
         else if (irq_ack || (ctrl_we && !ctrl_wdata[6])) m_irq = 0;
         if (ctrl_we && ctrl_wdata[0]) begin
            m_cnt = 0; m_idx = 0; m_done = 0; m_exp = ctrl_wdata[3];
         end else if (!m_ctl[0]) begin
            m_cnt++;
         end else if (!m_done) begin
            hit = m_exp ? rs : fl;
            if (hit) begin
               m_cap[2] = m_cap[1]; m_cap[1] = m_cap[0]; m_cap[0] = m_cnt;
               m_exp = !m_exp; m_idx++;
               if (m_ctl[2] && m_idx == 3) m_done = 1;
            end
            if (m_ctl[2]) m_cnt++;
            else if (m_cnt == m_term) m_done = 1;
            else m_cnt++;
         end
         if (ctrl_we) m_ctl = ctrl_wdata[5:0];
         if (term_we) m_term = term_wdata;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = ir_in;
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         chk("R11 ctrl_rdata", ctrl_rdata, {m_irq, m_ctl});
         chk("R3 R7 count", count, m_cnt);
         chk("R12 cap_data", cap_data, {m_cap[2], m_cap[1], m_cap[0]});
         chk("R6 done", done, m_done);
         chk("R10 irq", irq, m_irq);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic wr_ctrl(input logic [6:0] d);
      @(negedge clk); ctrl_we = 1; ctrl_wdata = d;
      @(negedge clk); ctrl_we = 0;
   endtask

   task automatic wr_term(input logic [15:0] d);
      @(negedge clk); term_we = 1; term_wdata = d;
      @(negedge clk); term_we = 0;
   endtask

   task automatic set_ir(input logic v);
      @(negedge clk); ir_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [15:0] v, w;
      logic [47:0] snap;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 count", count, 0);
      chk("R1 ctrl", ctrl_rdata, 0);
      chk("R1 caps", cap_data, 0);
      chk("R1 flags", {done, irq}, 0);
      @(negedge clk); rst_n = 1;

      // R3 / R10: disabled, pol=1, both edges raise the flag
      wr_ctrl(7'b0110010);
      @(negedge clk); v = count;
      @(negedge clk); chk("R3 timer step", count, v + 16'd1);
      set_ir(1); idle(5); set_ir(0); idle(5);
      chk("R3 no capture while disabled", cap_data, 0);
      chk("R10 flag set", irq, 1);
      @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
      chk("R11 ack clears", irq, 0);

      // R4: flipping polarity on a steady carrier gives no edge
      wr_ctrl(7'b0110000); idle(5);
      chk("R4 polarity flip no irq", irq, 0);
      wr_ctrl(7'b0110010); idle(5);
      chk("R4 polarity flip back no irq", irq, 0);

      // single mode, phase 0, pol 1; carrier starts high
      set_ir(1); idle(4); wr_ctrl(7'b0000000);
      wr_ctrl(7'b0000111);
      chk("R8 rearm zero", count, 0);
      @(negedge clk); ir_in = 0;
      @(posedge clk); @(posedge clk); #1 v = count;
      @(posedge clk); #1 chk("R2 latency stamp", cap_data[15:0], v);
      idle(6); set_ir(1); idle(6); set_ir(0); idle(6);
      chk("R6 done after three", done, 1);
      v = count; snap = cap_data;
      set_ir(1); idle(6);
      chk("R6 count holds", count, v);
      chk("R6 no extra capture", cap_data, snap);
      chk("R12 order", (cap_data[15:0] > cap_data[31:16]) && (cap_data[31:16] > cap_data[47:32]), 1);

      // phase 1 with a leading falling edge that must be skipped
      wr_ctrl(7'b0001111);
      snap = cap_data;
      set_ir(0); idle(6);
      chk("R9 mismatched edge ignored", cap_data, snap);
      set_ir(1); idle(6);
      chk("R5 rising first", cap_data[31:0], {snap[15:0], cap_data[15:0]});
      chk("R8 caps kept", cap_data[47:32], snap[31:16]);
      set_ir(0); idle(6); set_ir(1); idle(6);
      chk("R5 three captures done", done, 1);

      // pol 0: falling of inverted carrier is a rising input edge
      set_ir(0); idle(4);
      wr_ctrl(7'b0000101);
      snap = cap_data;
      set_ir(1); idle(6);
      chk("R4 inverted capture", cap_data[31:16], snap[15:0]);

      // continuous mode up to a terminal value
      wr_term(16'd40);
      wr_ctrl(7'b0000011);
      for (int k = 0; k < 8; k++) begin set_ir(~ir_in); idle(5); end
      idle(20);
      chk("R7 done at terminal", done, 1);
      chk("R7 count holds at terminal", count, 16'd40);

      // R11: write 0 to the flag bit clears it
      wr_ctrl(7'b0110010); set_ir(~ir_in); idle(5);
      chk("R10 flag again", irq, 1);
      wr_ctrl(7'b0110010);
      chk("R11 write clears", irq, 0);

      // random stress against the model
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         ctrl_we = 0; term_we = 0; irq_ack = 0;
         if ($urandom_range(3) == 0) ir_in = ~ir_in;
         if ($urandom_range(39) == 0) begin
            ctrl_we = 1; ctrl_wdata = 7'($urandom_range(127));
         end
         if ($urandom_range(59) == 0) begin
            term_we = 1; term_wdata = 16'($urandom_range(200));
         end
         if ($urandom_range(29) == 0) irq_ack = 1;
      end
      @(negedge clk); ctrl_we = 0; term_we = 0; irq_ack = 0;
      idle(4);
      w = count;
      chk("R1 run survived", (w === 16'hxxxx), 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule